// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Peak-Level Fields

This block is the master-side output stage of a stereo converter. It accepts a pair of parallel two's-complement samples, one for the left channel and one for the right, on a single valid strobe. It sends them on one serial data line together with the bit clock and the channel-select clock, and derives both clocks from the master clock that runs the block. Both samples of a pair travel in the same output frame, so the receiver can treat them as taken at the same instant.

Each channel's 32-bit slot has two parts. The sample comes first, most significant bit first. An 8-bit peak-level field follows it, and a framing strobe is high for exactly that field. A tracker in each channel keeps the largest sample magnitude seen so far. A falling edge on an asynchronous update input moves that value into an output register, whose contents feed the peak field, and clears the tracker for the next interval. A static strap input selects how the field is coded. With the strap low the field carries the plain level. With it high the field carries a bar-graph thermometer code.

Top module: `stereo_peak_tx`

## Requirements
- R1: The bit clock has a period of 4 master clocks (2 high, 2 low), and the channel clock has a period of 256 master clocks. The channel clock changes only together with a falling bit-clock edge.
- R2: The data line changes only on falling bit-clock edges. The left slot starts one bit period after the channel clock falls, and the right slot starts one bit period after it rises. Each slot carries the 24-bit sample MSB first, followed by the 8-bit peak field MSB first.
- R3: The left and right samples given on one valid strobe are sent in the same frame. This is the first frame whose left slot starts after the strobe.
- R4: For each sample, the peak tracker forms a level from bits 22..15 of the sample's magnitude. The tracker holds the largest such level since it was last cleared.
- R5: The most negative sample (0x800000) is treated as magnitude 0x7FFFFF, which gives level 0xFF.
- R6: The framing strobe is high for exactly the 8 bit periods of each peak field. It rises and falls with falling bit-clock edges.
- R7: A falling edge on the update input passes through a two-flop synchronizer and acts on the third rising master-clock edge after the input falls. At that edge it copies the tracker into the output register and clears the tracker. The peak field of each slot is taken from the output register at the moment the left slot starts.
- R8: When an update edge and a valid strobe act on the same clock edge, the clear wins. The output register receives the level from before that sample. The tracker then holds that sample's level alone.
- R9: With the strap high, the peak field is a thermometer code. If n is the 1-based position of the highest set bit of the level (0 for a zero level), the lowest n bits are set. With the strap low, the field is the level itself.
- R10: While reset is high, the bit clock, channel clock, data line and framing strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe that accepts a left/right pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| pk_update | input | 1 | Asynchronous update input; acts on its falling edge |
| bar_strap | input | 1 | Peak field coding: 0 plain level, 1 thermometer |
| bclk | output | 1 | Bit clock, 64 times the sample rate |
| lrclk | output | 1 | Channel clock; low for the left channel |
| sdata | output | 1 | Serial data line |
| pk_frame | output | 1 | High during each peak field |

## Verification
The sweep applies zero, plus one, minus one, both full-scale extremes, values just above and below the level threshold at bit 15, and spread arithmetic patterns. Each uses a different value per channel, so a swapped or misordered bit, a swapped channel or a misplaced slot shows up in the decoded frame. The field coding alternates with every sample, so a wrong magnitude slice, a missing saturation or a faulty thermometer stands apart from a correct level. Separate runs send several samples before one update to show that the maximum is kept, send an update with no samples to show the clear, and align a sample with the update edge to show the priority order.

// File: rtl/stx_pkg.sv
package stx_pkg;
  // coding applied to the peak field of each slot
  typedef enum logic {
    FMT_LEVEL = 1'b0,
    FMT_BAR   = 1'b1
  } peak_fmt_e;

  // channel index, also the level of the channel clock during its slot
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/stx_clkgen.sv
module stx_clkgen #(
  parameter int MCLK_DIV = 4,
  parameter int FRAME_W  = 64,
  localparam int DIV_W   = $clog2(MCLK_DIV),
  localparam int BIT_W   = $clog2(FRAME_W),
  localparam int CNT_W   = DIV_W + BIT_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             tick_o,
  output logic [BIT_W-1:0] nbit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             bclk_q;
  logic             lrclk_q;

  assign cnt_n  = cnt_q + 1'b1;
  // next cycle begins a new bit period
  assign tick_o = &cnt_q[DIV_W-1:0];
  assign nbit_o = cnt_n[CNT_W-1:DIV_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      bclk_q  <= 1'b0;
      lrclk_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      bclk_q  <= cnt_n[DIV_W-1];
      lrclk_q <= cnt_n[CNT_W-1];
    end
  end

  assign bclk_o  = bclk_q;
  assign lrclk_o = lrclk_q;

  // R1
  lr_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk_q) |-> $fell(bclk_q));

  // R1
  bclk_low_half_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk_q) |=> !bclk_q);
endmodule

// File: rtl/stx_peak.sv
module stx_peak #(
  parameter int SAMPLE_W = 24,
  parameter int PEAK_W   = 8,
  localparam int N_W     = $clog2(PEAK_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_v_i,
  input  logic [SAMPLE_W-1:0]   smp_i,
  input  logic                  clr_i,
  input  stx_pkg::peak_fmt_e    fmt_i,
  output logic [PEAK_W-1:0]     pk_o
);
  logic [SAMPLE_W-1:0] neg;
  logic [SAMPLE_W-1:0] mag;
  logic [PEAK_W-1:0]   lvl;
  logic [PEAK_W-1:0]   act_q;
  logic [PEAK_W-1:0]   out_q;
  logic [N_W-1:0]      top_n;
  logic [PEAK_W-1:0]   bar;

  // magnitude, saturating the most negative code
  always_comb begin
    neg = -smp_i;
    if (!smp_i[SAMPLE_W-1])
      mag = smp_i;
    else if (neg[SAMPLE_W-1])
      mag = {1'b0, {(SAMPLE_W-1){1'b1}}};
    else
      mag = neg;
  end

  assign lvl = mag[SAMPLE_W-2 -: PEAK_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      out_q <= '0;
    end else if (clr_i) begin
      out_q <= act_q;
      act_q <= smp_v_i ? lvl : '0;
    end else if (smp_v_i && (lvl > act_q)) begin
      act_q <= lvl;
    end
  end

  // thermometer: count equals 1-based index of highest set bit
  always_comb begin
    top_n = '0;
    for (int i = 0; i < PEAK_W; i++)
      if (out_q[i]) top_n = N_W'(i + 1);
    for (int i = 0; i < PEAK_W; i++)
      bar[i] = (N_W'(i) < top_n);
  end

  assign pk_o = (fmt_i == stx_pkg::FMT_BAR) ? bar : out_q;

  // R4
  act_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (act_q >= $past(act_q)));

  // R7
  act_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !smp_v_i) |=> (act_q == '0));

  // R8
  clr_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && smp_v_i) |=> (act_q == $past(lvl)));
endmodule

// File: rtl/stx_serializer.sv
module stx_serializer #(
  parameter int SAMPLE_W = 24,
  parameter int PEAK_W   = 8,
  localparam int SLOT_W  = SAMPLE_W + PEAK_W,
  localparam int FRAME_W = 2 * SLOT_W,
  localparam int BIT_W   = $clog2(FRAME_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic [BIT_W-1:0]    nbit_i,
  input  logic [SAMPLE_W-1:0] smp_l_i,
  input  logic [SAMPLE_W-1:0] smp_r_i,
  input  logic [PEAK_W-1:0]   pk_l_i,
  input  logic [PEAK_W-1:0]   pk_r_i,
  output logic                sdata_o,
  output logic                frame_o
);
  logic [FRAME_W-1:0] word;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0]   pos;
  logic               in_pk;
  logic               sd_q;
  logic               fr_q;

  assign word = {smp_l_i, pk_l_i, smp_r_i, pk_r_i};
  // stream position trails the bit index by one period
  assign pos  = nbit_i - 1'b1;
  assign in_pk = ((pos >= BIT_W'(SAMPLE_W)) && (pos < BIT_W'(SLOT_W))) ||
                 (pos >= BIT_W'(SLOT_W + SAMPLE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      sd_q <= 1'b0;
      fr_q <= 1'b0;
    end else if (tick_i) begin
      fr_q <= in_pk;
      if (nbit_i == BIT_W'(1)) begin
        sd_q <= word[FRAME_W-1];
        sh_q <= word << 1;
      end else begin
        sd_q <= sh_q[FRAME_W-1];
        sh_q <= sh_q << 1;
      end
    end
  end

  assign sdata_o = sd_q;
  assign frame_o = fr_q;

  // R6
  frame_width_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && (nbit_i == BIT_W'(SAMPLE_W + 1))) |=> fr_q);
endmodule

// File: rtl/stereo_peak_tx.sv
module stereo_peak_tx #(
  parameter int SAMPLE_W = 24,
  parameter int PEAK_W   = 8,
  parameter int MCLK_DIV = 4,
  localparam int SLOT_W  = SAMPLE_W + PEAK_W,
  localparam int FRAME_W = 2 * SLOT_W,
  localparam int BIT_W   = $clog2(FRAME_W),
  localparam int N_CH    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                pk_update,
  input  logic                bar_strap,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                pk_frame
);
  logic [2:0]          upd_s;
  logic                upd_fall;
  logic [SAMPLE_W-1:0] hold_q [N_CH];
  logic [SAMPLE_W-1:0] smp_in [N_CH];
  logic [PEAK_W-1:0]   pk_fmt [N_CH];
  logic                tick;
  logic [BIT_W-1:0]    nbit;
  stx_pkg::peak_fmt_e  fmt;

  assign fmt = bar_strap ? stx_pkg::FMT_BAR : stx_pkg::FMT_LEVEL;
  assign smp_in[stx_pkg::CH_LEFT]  = smp_left;
  assign smp_in[stx_pkg::CH_RIGHT] = smp_right;

  // two-flop synchronizer plus edge register; idles high
  always_ff @(posedge clk) begin
    if (rst) upd_s <= 3'b111;
    else     upd_s <= {upd_s[1:0], pk_update};
  end
  assign upd_fall = upd_s[2] & ~upd_s[1];

  stx_clkgen #(.MCLK_DIV(MCLK_DIV), .FRAME_W(FRAME_W)) u_clk (
    .clk(clk), .rst(rst), .bclk_o(bclk), .lrclk_o(lrclk),
    .tick_o(tick), .nbit_o(nbit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)            hold_q[c] <= '0;
      else if (smp_valid) hold_q[c] <= smp_in[c];
    end

    stx_peak #(.SAMPLE_W(SAMPLE_W), .PEAK_W(PEAK_W)) u_peak (
      .clk(clk), .rst(rst), .smp_v_i(smp_valid), .smp_i(smp_in[c]),
      .clr_i(upd_fall), .fmt_i(fmt), .pk_o(pk_fmt[c])
    );
  end

  stx_serializer #(.SAMPLE_W(SAMPLE_W), .PEAK_W(PEAK_W)) u_ser (
    .clk(clk), .rst(rst), .tick_i(tick), .nbit_i(nbit),
    .smp_l_i(hold_q[stx_pkg::CH_LEFT]), .smp_r_i(hold_q[stx_pkg::CH_RIGHT]),
    .pk_l_i(pk_fmt[stx_pkg::CH_LEFT]), .pk_r_i(pk_fmt[stx_pkg::CH_RIGHT]),
    .sdata_o(sdata), .frame_o(pk_frame)
  );

  // R2
  sdata_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk));

  // R6
  frame_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pk_frame) |-> $fell(bclk));

  // R10
  always_ff @(posedge clk) begin
    if (rst && $past(rst))
      reset_quiet_chk: assert (!bclk && !lrclk && !sdata && !pk_frame);
  end
endmodule

// File: tb/stereo_peak_tx_tb.sv
module stereo_peak_tx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [23:0] smp_left = '0;
  logic [23:0] smp_right = '0;
  logic pk_update = 1'b1;
  logic bar_strap = 1'b0;
  logic bclk, lrclk, sdata, pk_frame;
  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [63:0] f_dat, f_frm, f_lr;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stereo_peak_tx u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .pk_update(pk_update), .bar_strap(bar_strap),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .pk_frame(pk_frame)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lvl_of(input logic [23:0] s);
    int m;
    m = $signed(s);
    if (m < 0) m = -m;
    if (m > 8388607) m = 8388607;
    return 8'(m >> 15);
  endfunction

  function automatic logic [7:0] fmt_of(input logic [7:0] v, input bit bar);
    int n;
    logic [8:0] t;
    if (!bar) return v;
    n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n = i + 1;
    t = (9'd1 << n) - 9'd1;
    return t[7:0];
  endfunction

  function automatic logic [23:0] sweep_val(input int i);
    case (i)
      0: return 24'h000000;
      1: return 24'h000001;
      2: return 24'hFFFFFF;
      3: return 24'h7FFFFF;
      4: return 24'h800000;
      5: return 24'h008000;
      6: return 24'h007FFF;
      7: return 24'hFF8000;
      8: return 24'h400000;
      9: return 24'hC00001;
      default: return 24'(i * 24'h0A3D71) ^ 24'h13579B;
    endcase
  endfunction

  task automatic send(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    smp_left = l; smp_right = r; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic update();
    @(negedge clk);
    pk_update = 1'b0;
    repeat (6) @(negedge clk);
    pk_update = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // collects stream positions 0..63 of the next frame
  task automatic grab();
    @(negedge lrclk);
    @(posedge bclk);
    for (int k = 0; k < 64; k++) begin
      @(posedge bclk);
      #1;
      f_dat[63-k] = sdata;
      f_frm[63-k] = pk_frame;
      f_lr[63-k]  = lrclk;
    end
  endtask

  task automatic chk_peaks(input logic [7:0] el, input logic [7:0] er, input string tag);
    chk(f_dat[39:32] == el, {tag, " left peak"}, f_dat[39:32], el);
    chk(f_dat[7:0] == er, {tag, " right peak"}, f_dat[7:0], er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int t0, t1;
    logic [63:0] exp_frm, exp_lr;
    logic [23:0] l, r;
    bit b;
    exp_frm = {8'h00, 16'h0000, 8'hFF, 8'h00, 16'h0000, 8'hFF};
    exp_lr  = '0;
    for (int k = 31; k < 63; k++) exp_lr[63-k] = 1'b1;

    repeat (5) @(negedge clk);
    // R10 reset state
    chk({bclk, lrclk, sdata, pk_frame} == 4'b0, "R10 outputs in reset",
        {bclk, lrclk, sdata, pk_frame}, 0);
    rst = 1'b0;

    // R1 clock ratios
    @(posedge bclk); t0 = cyc;
    @(negedge bclk); t1 = cyc;
    chk(t1 - t0 == 2, "R1 bclk high time", t1 - t0, 2);
    @(posedge bclk); t1 = cyc;
    chk(t1 - t0 == 4, "R1 bclk period", t1 - t0, 4);
    @(posedge lrclk); t0 = cyc;
    @(posedge lrclk); t1 = cyc;
    chk(t1 - t0 == 256, "R1 lrclk period", t1 - t0, 256);

    // sweep: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 14; i++) begin
      l = sweep_val(i);
      r = sweep_val(13 - i);
      b = i[0];
      bar_strap = b;
      send(l, r);
      update();
      grab();
      chk(f_dat[63:40] == l, "R2 left sample", f_dat[63:40], l);
      chk(f_dat[31:8] == r, "R3 right sample same frame", f_dat[31:8], r);
      chk_peaks(fmt_of(lvl_of(l), b), fmt_of(lvl_of(r), b),
                (l == 24'h800000 || r == 24'h800000) ? "R5" : (b ? "R9" : "R4"));
      chk(f_frm == exp_frm, "R6 strobe window", f_frm, exp_frm);
      chk(f_lr == exp_lr, "R2 lrclk per position", f_lr, exp_lr);
    end

    bar_strap = 1'b0;
    // R4 maximum kept across samples
    send(24'h080000, 24'h200000);
    send(24'h200000, 24'h100000);
    send(24'h100000, 24'h080000);
    update();
    grab();
    chk_peaks(8'h40, 8'h40, "R4 max");

    // R7 update with no samples gives cleared level
    update();
    grab();
    chk_peaks(8'h00, 8'h00, "R7 clear");

    // R8 sample coincident with update edge
    send(24'h400000, 24'h400000);
    @(negedge clk);
    pk_update = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    smp_left = 24'h088000; smp_right = 24'h088000; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (6) @(negedge clk);
    pk_update = 1'b1;
    repeat (6) @(negedge clk);
    grab();
    chk_peaks(8'h80, 8'h80, "R8 pre-sample level");
    update();
    grab();
    chk_peaks(8'h11, 8'h11, "R8 new sample in cleared tracker");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule